// File: doc/BRIEF.md
# Wormhole Source-Routed Four-Port Crossbar

This block is a four-port switch. Each port has a receive side and a transmit side, so a link from a neighbour can connect to it in both directions. A message arrives on a receive side as a stream of bytes. The first byte is a route byte carried at the front of the message; no routing table is consulted. The two low bits of the route byte name the transmit port. The switch consumes the route byte and does not forward it. It then competes for the named output. Once it wins, it holds that output for the whole message: the wormhole stays open until the byte marked as tail has left the switch. The following hop therefore sees the next route byte at the front of the stream.

Every byte travels through a fixed delay line, so an uncontended message keeps a constant fall-through time of six cycles from its route byte to its first forwarded byte. A round-robin arbiter settles contention for an output, and the inputs that lose wait without losing any bytes. Each port has a valid/ready handshake and a tail marker. A transmit port that deasserts ready freezes the connection that feeds it.

Top module: `wormhole_xbar`

## Requirements
- R1: Directly after reset, every outValid bit is 0 and every inReady bit is 1.
- R2: Bits [1:0] of a message's first byte select the output, and bits [7:2] of that byte are ignored. That byte is not forwarded. The remaining bytes come out in order, and outTail is set only with the last one.
- R3: Without contention or backpressure, the byte after the route byte is on its output exactly 6 cycles after the cycle in which the route byte was accepted. Later bytes follow on consecutive cycles.
- R4: An output carries one message at a time from its first byte to its tail. Other messages for it wait and never interleave, and an input holds at most one output.
- R5: Contention is settled round-robin. Right after reset, input 0 has the highest priority. After each grant, the winner drops to the lowest priority.
- R6: If an output forwards a tail byte in cycle t, that output shows outValid low in cycle t+1. A message waiting for the output shows its first byte there in cycle t+6.
- R7: While outValid is high and outReady is low, outValid, outData and outTail hold their values. No byte is lost or duplicated.
- R8: A route byte that carries the tail flag is consumed and discarded. It opens no connection and produces no output activity.
- R9: Messages from different inputs to different outputs pass concurrently, and each keeps the latency of R3.
- R10: An output that has no message routed to it keeps outValid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inData | input | 32 | Receive bytes, port p on bits [8p+7:8p] |
| inValid | input | 4 | Receive byte valid, one bit per port |
| inTail | input | 4 | Last byte of the message, one bit per port |
| inReady | output | 4 | Receive side accepts the byte this cycle |
| outData | output | 32 | Transmit bytes, port p on bits [8p+7:8p] |
| outValid | output | 4 | Transmit byte valid, one bit per port |
| outTail | output | 4 | Transmit byte is the last of its message |
| outReady | input | 4 | Downstream accepts the transmit byte |

## Verification
The bench first sweeps every input against every output, one at a time. Each route byte carries junk in its upper bits and the messages have varying lengths. This separates correct steering, route stripping and the exact fall-through from leaks onto idle outputs. It then runs the three rotations in which all four inputs target distinct outputs at once, which shows whether connections are truly independent. All four inputs then hit one output together. The grant order and the six-cycle gap after each tail tell round-robin rotation and the timing of release apart from merely serialising the messages. A toggling outReady tests loss and duplication under stalls, and a lone tail-flagged route byte checks that a degenerate message is dropped.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int PORTS = 4;
  localparam int SELW  = $clog2(PORTS);
  localparam int BYTEW = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic [PORTS-1:0]           load;   // per input: capture byte into first stage
    logic [PORTS-1:0]           adv;    // per input: shift the delay line
    logic [PORTS-1:0]           outEn;  // per output: a connection holds it
    logic [PORTS-1:0][SELW-1:0] outSel; // per output: owning input
  } xbarStrobe_t;

  typedef enum logic [1:0] {IN_IDLE, IN_REQ, IN_CONN, IN_DRAIN} inState_t;
endpackage

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gntIdx
);
  logic [IW-1:0] ptr;

  always_comb begin
    gnt    = '0;
    gntIdx = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N;
      if (gnt == '0 && req[idx]) begin
        gnt[idx] = 1'b1;
        gntIdx   = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (|gnt) ptr <= IW'((int'(gntIdx) + 1) % N);
  end
endmodule

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PORTS-1:0]      inValid,
  input  logic [PORTS-1:0]      inTail,
  input  logic [SELW-1:0]       routeLow [PORTS],
  input  logic [PORTS-1:0]      outReady,
  input  logic [PORTS-1:0]      tailAtHead,
  output logic [PORTS-1:0]      inReady,
  output xbarStrobe_t           strb
);
  inState_t         st    [PORTS];
  logic [SELW-1:0]  port  [PORTS];
  logic [PORTS-1:0] busy;
  logic [SELW-1:0]  owner [PORTS];

  logic [PORTS-1:0] reqVec [PORTS];
  logic [PORTS-1:0] gntVec [PORTS];
  logic [SELW-1:0]  gntIdx [PORTS];
  logic [PORTS-1:0] granted, linked, portReady, finish;

  always_comb begin
    for (int o = 0; o < PORTS; o++)
      for (int i = 0; i < PORTS; i++)
        reqVec[o][i] = (st[i] == IN_REQ) && (port[i] == SELW'(o)) && !busy[o];
  end

  for (genvar o = 0; o < PORTS; o++) begin : g_arb
    xbar_rr_arb #(.N(PORTS)) u_arb (
      .clk(clk), .rst(rst), .req(reqVec[o]), .gnt(gntVec[o]), .gntIdx(gntIdx[o])
    );
  end

  always_comb begin
    for (int i = 0; i < PORTS; i++) begin
      granted[i] = 1'b0;
      for (int o = 0; o < PORTS; o++) granted[i] = granted[i] | gntVec[o][i];
      portReady[i] = outReady[port[i]];
      linked[i]    = (st[i] == IN_CONN) || (st[i] == IN_DRAIN) ||
                     ((st[i] == IN_REQ) && granted[i]);
      inReady[i]   = (st[i] == IN_IDLE) ||
                     (((st[i] == IN_CONN) || ((st[i] == IN_REQ) && granted[i])) && portReady[i]);
      strb.load[i] = inValid[i] && inReady[i] && (st[i] != IN_IDLE);
      strb.adv[i]  = linked[i] ? portReady[i] : 1'b1;
      finish[i]    = (st[i] == IN_DRAIN) && tailAtHead[i] && portReady[i];
    end
    strb.outEn = busy;
    for (int o = 0; o < PORTS; o++) strb.outSel[o] = owner[o];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PORTS; i++) begin
        st[i]   <= IN_IDLE;
        port[i] <= '0;
      end
    end else begin
      for (int i = 0; i < PORTS; i++) begin
        unique case (st[i])
          IN_IDLE:  if (inValid[i] && !inTail[i]) begin
                      port[i] <= routeLow[i];
                      st[i]   <= IN_REQ;
                    end
          IN_REQ:   if (granted[i]) st[i] <= (strb.load[i] && inTail[i]) ? IN_DRAIN : IN_CONN;
          IN_CONN:  if (strb.load[i] && inTail[i]) st[i] <= IN_DRAIN;
          IN_DRAIN: if (finish[i]) st[i] <= IN_IDLE;
          default:  st[i] <= IN_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= '0;
      for (int o = 0; o < PORTS; o++) owner[o] <= '0;
    end else begin
      for (int o = 0; o < PORTS; o++) begin
        if (|gntVec[o]) begin
          busy[o]  <= 1'b1;
          owner[o] <= gntIdx[o];
        end else if (busy[o] && finish[owner[o]]) begin
          busy[o]  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/xbar_datapath.sv
module xbar_datapath
  import xbar_pkg::*;
#(
  parameter int PIPE = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PORTS*BYTEW-1:0]   inData,
  input  logic [PORTS-1:0]         inTail,
  input  xbarStrobe_t              strb,
  output logic [PORTS*BYTEW-1:0]   outData,
  output logic [PORTS-1:0]         outValid,
  output logic [PORTS-1:0]         outTail,
  output logic [PORTS-1:0]         tailAtHead
);
  logic [PORTS-1:0] headVld, headTl;
  logic [BYTEW-1:0] headDat [PORTS];

  for (genvar i = 0; i < PORTS; i++) begin : g_lane
    logic [PIPE-1:0]  vld, tl;
    logic [BYTEW-1:0] dat [PIPE];

    always_ff @(posedge clk) begin
      if (rst) begin
        vld <= '0;
        tl  <= '0;
        for (int s = 0; s < PIPE; s++) dat[s] <= '0;
      end else if (strb.adv[i]) begin
        vld[0] <= strb.load[i];
        tl[0]  <= inTail[i];
        dat[0] <= inData[i*BYTEW +: BYTEW];
        for (int s = 1; s < PIPE; s++) begin
          vld[s] <= vld[s-1];
          tl[s]  <= tl[s-1];
          dat[s] <= dat[s-1];
        end
      end
    end

    assign headVld[i]    = vld[PIPE-1];
    assign headTl[i]     = tl[PIPE-1];
    assign headDat[i]    = dat[PIPE-1];
    assign tailAtHead[i] = vld[PIPE-1] & tl[PIPE-1];
  end

  always_comb begin
    for (int o = 0; o < PORTS; o++) begin
      outValid[o]                 = strb.outEn[o] & headVld[strb.outSel[o]];
      outTail[o]                  = strb.outEn[o] & headVld[strb.outSel[o]] & headTl[strb.outSel[o]];
      outData[o*BYTEW +: BYTEW]   = headDat[strb.outSel[o]];
    end
  end
endmodule

// File: rtl/wormhole_xbar.sv
module wormhole_xbar
  import xbar_pkg::*;
#(
  parameter int LATENCY = 6,
  localparam int PIPE = LATENCY - 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PORTS*BYTEW-1:0] inData,
  input  logic [PORTS-1:0]       inValid,
  input  logic [PORTS-1:0]       inTail,
  output logic [PORTS-1:0]       inReady,
  output logic [PORTS*BYTEW-1:0] outData,
  output logic [PORTS-1:0]       outValid,
  output logic [PORTS-1:0]       outTail,
  input  logic [PORTS-1:0]       outReady
);
  xbarStrobe_t      strb;
  logic [PORTS-1:0] tailAtHead;
  logic [SELW-1:0]  routeLow [PORTS];

  for (genvar i = 0; i < PORTS; i++) begin : g_route
    assign routeLow[i] = inData[i*BYTEW +: SELW];
  end

  xbar_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inTail(inTail), .routeLow(routeLow),
    .outReady(outReady), .tailAtHead(tailAtHead), .inReady(inReady), .strb(strb)
  );

  xbar_datapath #(.PIPE(PIPE)) u_dp (
    .clk(clk), .rst(rst), .inData(inData), .inTail(inTail), .strb(strb),
    .outData(outData), .outValid(outValid), .outTail(outTail), .tailAtHead(tailAtHead)
  );
endmodule

// File: rtl/xbar_checker.sv
module xbar_checker
  import xbar_pkg::*;
(
  input logic                           clk,
  input logic                           rst,
  input logic [PORTS*BYTEW-1:0]         outData,
  input logic [PORTS-1:0]               outValid,
  input logic [PORTS-1:0]               outTail,
  input logic [PORTS-1:0]               outReady,
  input logic [PORTS-1:0]               outEn,
  input logic [PORTS-1:0][SELW-1:0]     outSel
);
  for (genvar o = 0; o < PORTS; o++) begin : g_out
    // R1: quiet outputs leaving reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !outValid[o]);
    // R7: stalled byte is held unchanged
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
      (outValid[o] && !outReady[o]) |=>
        (outValid[o] && $stable(outData[o*BYTEW +: BYTEW]) && $stable(outTail[o])));
    // R6: output goes idle the cycle after its tail leaves
    p_release_gap_r6: assert property (@(posedge clk) disable iff (rst)
      (outValid[o] && outTail[o] && outReady[o]) |=> !outValid[o]);
  end

  for (genvar i = 0; i < PORTS; i++) begin : g_in
    logic [PORTS-1:0] ownCol;
    for (genvar o = 0; o < PORTS; o++) begin : g_col
      assign ownCol[o] = outEn[o] && (outSel[o] == SELW'(i));
    end
    // R4: an input holds at most one output
    p_single_owner_r4: assert property (@(posedge clk) disable iff (rst)
      $onehot0(ownCol));
  end
endmodule

bind wormhole_xbar xbar_checker u_chk (
  .clk(clk), .rst(rst), .outData(outData), .outValid(outValid), .outTail(outTail),
  .outReady(outReady), .outEn(strb.outEn), .outSel(strb.outSel)
);

// File: tb/tb_wormhole_xbar.sv
module tb_wormhole_xbar;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] inData = '0;
  logic [3:0]  inValid = '0, inTail = '0, outReady = 4'hF;
  logic [3:0]  inReady, outValid, outTail;
  logic [31:0] outData;

  wormhole_xbar dut (.*);

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, fails = 0;
  bit done = 0;

  logic [7:0] rxData [4][$];
  bit         rxTail [4][$];
  int         rxCyc  [4][$];

  initial forever begin
    @(negedge clk); #2;
    if (!rst)
      for (int o = 0; o < 4; o++)
        if (outValid[o] && outReady[o]) begin
          rxData[o].push_back(outData[o*8 +: 8]);
          rxTail[o].push_back(outTail[o]);
          rxCyc[o].push_back(cyc);
        end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearRx();
    for (int o = 0; o < 4; o++) begin
      rxData[o].delete(); rxTail[o].delete(); rxCyc[o].delete();
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; inValid = '0; inTail = '0; outReady = 4'hF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic sendByte(input int p, input logic [7:0] d, input logic t, output int acc);
    @(negedge clk);
    inValid[p] = 1'b1; inData[p*8 +: 8] = d; inTail[p] = t;
    #1;
    while (!inReady[p]) begin @(negedge clk); #1; end
    acc = cyc;
    @(posedge clk);
  endtask

  function automatic logic [7:0] payload(input int src, input int k);
    return 8'(src * 64 + k);
  endfunction

  task automatic sendMsg(input int p, input logic [7:0] route, input int len, output int routeCyc);
    int a;
    sendByte(p, route, 1'b0, routeCyc);
    for (int k = 0; k < len; k++) sendByte(p, payload(p, k), (k == len - 1), a);
    @(negedge clk); inValid[p] = 1'b0; inTail[p] = 1'b0;
  endtask

  task automatic verifyMsg(input int o, input int start, input int src, input int len,
                           input int expCyc, input string req);
    int bad = 0;
    check(rxData[o].size() >= start + len, req, "byte count", rxData[o].size(), start + len);
    if (rxData[o].size() >= start + len) begin
      for (int k = 0; k < len; k++) begin
        if (rxData[o][start+k] !== payload(src, k)) bad++;
        if (rxTail[o][start+k] !== (k == len - 1)) bad++;
      end
      check(bad == 0, req, "payload/tail mismatches", bad, 0);
      check(rxCyc[o][start] == expCyc, req, "first byte cycle", rxCyc[o][start], expCyc);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int rc [4];
    doReset();
    @(negedge clk); #2;
    check(outValid == 4'h0, "R1", "outValid after reset", outValid, 0);
    check(inReady == 4'hF, "R1", "inReady after reset", inReady, 15);

    // R2 R3 R10: every input to every output in turn
    for (int i = 0; i < 4; i++)
      for (int o = 0; o < 4; o++) begin
        int len = 1 + ((i + o) % 4);
        int r;
        int stray = 0;
        clearRx();
        sendMsg(i, {6'(i * 4 + o + 1), 2'(o)}, len, r);
        repeat (12) @(negedge clk);
        verifyMsg(o, 0, i, len, r + 6, "R2/R3");
        check(rxData[o].size() == len, "R2", "exact byte count", rxData[o].size(), len);
        for (int x = 0; x < 4; x++) if (x != o) stray += rxData[x].size();
        check(stray == 0, "R10", "bytes on idle outputs", stray, 0);
      end

    // R9: three rotations with all inputs busy on distinct outputs
    for (int k = 1; k < 4; k++) begin
      clearRx();
      for (int i = 0; i < 4; i++) begin
        fork
          automatic int ii = i;
          automatic int kk = k;
          begin
            int r;
            sendMsg(ii, 8'((ii + kk) % 4), 5, r);
            rc[ii] = r;
          end
        join_none
      end
      wait fork;
      repeat (12) @(negedge clk);
      for (int o = 0; o < 4; o++) verifyMsg(o, 0, (o - k + 4) % 4, 5, rc[(o - k + 4) % 4] + 6, "R9");
    end

    // R4 R5 R6: all inputs race for output 1 after a fresh reset
    doReset();
    clearRx();
    for (int i = 0; i < 4; i++) begin
      fork
        automatic int ii = i;
        begin
          int r;
          sendMsg(ii, 8'h01, 4, r);
          rc[ii] = r;
        end
      join_none
    end
    wait fork;
    repeat (12) @(negedge clk);
    check(rxData[1].size() == 16, "R4", "contended byte count", rxData[1].size(), 16);
    verifyMsg(1, 0, 0, 4, rc[0] + 6, "R5");
    for (int j = 1; j < 4; j++)
      if (rxData[1].size() >= 4 * j) verifyMsg(1, 4 * j, j, 4, rxCyc[1][4 * j - 1] + 6, "R4/R5/R6");

    // R7: toggling backpressure on output 3
    clearRx();
    begin
      bit stop = 0;
      int r;
      fork
        begin
          while (!stop) begin
            @(negedge clk); outReady[3] = ((cyc % 3) != 1);
          end
          outReady[3] = 1'b1;
        end
        begin
          sendMsg(2, 8'hFB, 10, r);
          repeat (30) @(negedge clk);
          stop = 1;
        end
      join
    end
    repeat (3) @(negedge clk);
    check(rxData[3].size() == 10, "R7", "bytes under backpressure", rxData[3].size(), 10);
    begin
      int bad = 0;
      for (int k = 0; k < 10 && k < rxData[3].size(); k++)
        if (rxData[3][k] !== payload(2, k) || rxTail[3][k] !== (k == 9)) bad++;
      check(bad == 0, "R7", "order/dup errors", bad, 0);
    end

    // R8: lone tail-flagged route byte is discarded
    clearRx();
    begin
      int a, r;
      sendByte(1, 8'h00, 1'b1, a);
      @(negedge clk); inValid[1] = 1'b0; inTail[1] = 1'b0;
      repeat (10) @(negedge clk);
      check(rxData[0].size() == 0, "R8", "bytes from discarded route", rxData[0].size(), 0);
      sendMsg(1, 8'h00, 3, r);
      repeat (12) @(negedge clk);
      verifyMsg(0, 0, 1, 3, r + 6, "R8");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule